// File: doc/BRIEF.md
# Burst Phase Selector

A burst-mode serial stream is sampled by four clocks of one frequency, spaced a quarter period apart. This block takes the four sampled lines, brings them onto common reference-phase timing, and looks for a short one-zero-one marker in each retimed stream. The search runs only during a bounded window after a burst-start pulse. The phase that first shows the marker is taken as sitting near a transition. The block then locks onto the phase half a period away from it, which lies mid-eye, and forwards that stream as recovered data. A valid flag and the chosen phase index come with the data.

Each line bit lasts `SPB` reference cycles, which is two at a 40 MHz reference and a 20 Mb/s line rate. A burst opens with a preamble of sixteen one bits, and the marker follows it. When the window runs out with no marker, a timeout flag is raised and the block waits for the next burst. The lock is held until an end-of-burst pulse, a new burst-start pulse or reset.

Top module: `burst_phase_sel`

## Requirements
- R1: While reset is held, and after it until the first burst, lock_o, valid_o and timeout_o are 0 and phase_o is 0.
- R2: While valid_o is 1, data_o in the cycle after edge t equals the sample of the phase given by phase_o that was taken at edge t-2. The latency is a fixed two reference cycles.
- R3: Phase p detects the marker at edge t when its samples taken at edges t-3, t-3-SPB and t-3-2*SPB are 1, 0 and 1.
- R4: phase_o is the index of the phase that detected first, plus NPH/2, modulo NPH. With four phases, a first detection on 0, 1, 2 or 3 selects 2, 3, 0 or 1.
- R5: When several phases detect at the same edge, the lowest-numbered of them decides the selection.
- R6: Detections count only at the WIN_CYC edges that follow the edge sampling burst_start_i. A marker seen later does not lock the block.
- R7: If the window closes without a detection, timeout_o goes to 1 and stays there while lock_o and valid_o stay 0, until the next burst_start_i or burst_end_i.
- R8: Once lock_o is 1, phase_o does not change until burst_end_i, burst_start_i or reset, whatever markers follow.
- R9: valid_o is 1 exactly in the cycles where lock_o was 1 in the previous cycle and burst_end_i was 0 at the edge between them.
- R10: burst_start_i drops the lock and clears timeout_o at the next edge, and a new search begins. burst_end_i drops the lock and valid_o at the next edge and clears timeout_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference-phase clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| burst_start_i | input | 1 | One-cycle pulse that opens a burst and its search window |
| burst_end_i | input | 1 | One-cycle pulse that closes a burst |
| samp_i | input | NPH | Sampled line bits, one per phase |
| data_o | output | 1 | Recovered bit from the selected phase |
| valid_o | output | 1 | data_o is meaningful |
| lock_o | output | 1 | A phase has been selected |
| phase_o | output | $clog2(NPH) | Index of the selected phase |
| timeout_o | output | 1 | The search window ended with no detection |

## Verification
The bench builds the block with NPH=4, SPB=2 and WIN_CYC=48. A marker placed after a 16-bit preamble is found about 38 cycles into the window, while a 30-bit preamble pushes the marker past the window. Both the lock path and the timeout path are therefore reached in short bursts. The four phases are modelled as delayed copies of a single waveform, so each phase in turn can be made the earliest, and two phases can be made to tie.

// File: rtl/bps_pkg.sv
package bps_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SEARCH = 2'd1,
    ST_LOCK   = 2'd2
  } bps_state_e;
endpackage

// File: rtl/bps_retime.sv
module bps_retime #(
  parameter int NPH = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NPH-1:0] samp_i,
  output logic [NPH-1:0] algn_o
);
  for (genvar p = 0; p < NPH; p++) begin : g_ph
    logic cap_q, algn_q;
    // capture stage, then common reference-phase stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cap_q  <= 1'b0;
        algn_q <= 1'b0;
      end else begin
        cap_q  <= samp_i[p];
        algn_q <= cap_q;
      end
    end
    assign algn_o[p] = algn_q;
  end
endmodule

// File: rtl/bps_detect.sv
module bps_detect #(
  parameter int                 NPH   = 4,
  parameter int                 SPB   = 2,
  parameter int                 PAT_W = 3,
  parameter logic [PAT_W-1:0]   PAT   = 3'b101
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NPH-1:0] algn_i,
  output logic [NPH-1:0] hit_o
);
  localparam int HLEN = (PAT_W - 1) * SPB + 1;

  for (genvar p = 0; p < NPH; p++) begin : g_ph
    logic [HLEN-1:0] hist_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) hist_q <= '0;
      else         hist_q <= {hist_q[HLEN-2:0], algn_i[p]};
    end
    // taps one bit period apart, bit 0 newest
    always_comb begin
      hit_o[p] = 1'b1;
      for (int k = 0; k < PAT_W; k++) begin
        if (hist_q[k*SPB] != PAT[k]) hit_o[p] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/bps_ctrl.sv
module bps_ctrl
  import bps_pkg::*;
#(
  parameter int NPH     = 4,
  parameter int WIN_CYC = 64
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   burst_start_i,
  input  logic                   burst_end_i,
  input  logic [NPH-1:0]         hit_i,
  output logic [$clog2(NPH)-1:0] sel_o,
  output logic                   lock_o,
  output logic                   srch_o,
  output logic                   tmo_o
);
  localparam int SW   = $clog2(NPH);
  localparam int CW   = $clog2(WIN_CYC + 1);
  localparam int HALF = NPH / 2;

  bps_state_e    st_q;
  logic [CW-1:0] cnt_q;
  logic [SW-1:0] sel_q, win, sel_d;
  logic          tmo_q;

  // lowest index wins a tie
  always_comb begin
    win = '0;
    for (int p = NPH - 1; p >= 0; p--) begin
      if (hit_i[p]) win = SW'(p);
    end
    sel_d = SW'((int'(win) + HALF) % NPH);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      sel_q <= '0;
      tmo_q <= 1'b0;
    end else if (burst_end_i) begin
      st_q  <= ST_IDLE;
      tmo_q <= 1'b0;
    end else if (burst_start_i) begin
      st_q  <= ST_SEARCH;
      cnt_q <= '0;
      tmo_q <= 1'b0;
    end else if (st_q == ST_SEARCH) begin
      if (|hit_i) begin
        st_q  <= ST_LOCK;
        sel_q <= sel_d;
      end else if (cnt_q == CW'(WIN_CYC - 1)) begin
        st_q  <= ST_IDLE;
        tmo_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign sel_o  = sel_q;
  assign lock_o = (st_q == ST_LOCK);
  assign srch_o = (st_q == ST_SEARCH);
  assign tmo_o  = tmo_q;
endmodule

// File: rtl/burst_phase_sel.sv
module burst_phase_sel #(
  parameter int               NPH     = 4,
  parameter int               SPB     = 2,
  parameter int               WIN_CYC = 64,
  parameter int               PAT_W   = 3,
  parameter logic [PAT_W-1:0] PAT     = 3'b101
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   burst_start_i,
  input  logic                   burst_end_i,
  input  logic [NPH-1:0]         samp_i,
  output logic                   data_o,
  output logic                   valid_o,
  output logic                   lock_o,
  output logic [$clog2(NPH)-1:0] phase_o,
  output logic                   timeout_o
);
  localparam int SW = $clog2(NPH);

  logic [NPH-1:0] algn, hit;
  logic [SW-1:0]  sel;
  logic           lock, srch, tmo;
  logic           dout_q, vld_q;

  bps_retime #(.NPH(NPH)) u_retime (
    .clk_i(clk_i), .rst_ni(rst_ni), .samp_i(samp_i), .algn_o(algn)
  );

  bps_detect #(.NPH(NPH), .SPB(SPB), .PAT_W(PAT_W), .PAT(PAT)) u_detect (
    .clk_i(clk_i), .rst_ni(rst_ni), .algn_i(algn), .hit_o(hit)
  );

  bps_ctrl #(.NPH(NPH), .WIN_CYC(WIN_CYC)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .burst_start_i(burst_start_i), .burst_end_i(burst_end_i),
    .hit_i(hit), .sel_o(sel), .lock_o(lock), .srch_o(srch), .tmo_o(tmo)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      dout_q <= algn[sel];
      vld_q  <= lock && !burst_end_i;
    end
  end

  assign data_o    = dout_q;
  assign valid_o   = vld_q;
  assign lock_o    = lock;
  assign phase_o   = sel;
  assign timeout_o = tmo;
endmodule

// File: rtl/bps_chk.sv
module bps_chk #(
  parameter int NPH = 4
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   burst_start_i,
  input logic                   burst_end_i,
  input logic                   lock_o,
  input logic                   valid_o,
  input logic                   timeout_o,
  input logic [$clog2(NPH)-1:0] phase_o,
  input logic                   srch_i
);
  p_phase_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_o && !burst_start_i && !burst_end_i) |=> (lock_o && $stable(phase_o)));

  p_valid_after_lock_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(lock_o));

  p_tmo_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> (!lock_o && !valid_o));

  p_tmo_from_search_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> $past(srch_i));

  p_lock_from_search_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(srch_i));

  p_end_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_end_i |=> (!lock_o && !valid_o && !timeout_o));

  p_start_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (burst_start_i && !burst_end_i) |=> (!lock_o && !timeout_o && srch_i));
endmodule

bind burst_phase_sel bps_chk #(.NPH(NPH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .burst_start_i(burst_start_i), .burst_end_i(burst_end_i),
  .lock_o(lock_o), .valid_o(valid_o), .timeout_o(timeout_o),
  .phase_o(phase_o), .srch_i(srch)
);

// File: tb/burst_phase_sel_tb_top.sv
`timescale 1ns/1ps
module burst_phase_sel_tb_top;
  localparam int NPH = 4;
  localparam int SPB = 2;
  localparam int WIN = 48;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic bs = 1'b0, be = 1'b0;
  logic [NPH-1:0] samp = '0;
  logic data_o, valid_o, lock_o, timeout_o;
  logic [1:0] phase_o;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk_i = ~clk_i;

  burst_phase_sel #(.NPH(NPH), .SPB(SPB), .WIN_CYC(WIN)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .burst_start_i(bs), .burst_end_i(be),
    .samp_i(samp), .data_o(data_o), .valid_o(valid_o), .lock_o(lock_o),
    .phase_o(phase_o), .timeout_o(timeout_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference
  logic [NPH-1:0] hq[$];
  int  m_st, m_cnt, m_sel;   // m_st: 0 idle, 1 search, 2 lock
  bit  m_tmo, m_vld, m_dat;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hq.delete();
      for (int i = 0; i < 8; i++) hq.push_back('0);
      m_st = 0; m_cnt = 0; m_sel = 0; m_tmo = 0; m_vld = 0; m_dat = 0;
    end else begin
      int first;
      hq.push_front(samp);
      void'(hq.pop_back());
      m_vld = (m_st == 2) && !be;
      m_dat = hq[2][m_sel];
      first = -1;
      for (int p = NPH - 1; p >= 0; p--)
        if (hq[3][p] && !hq[3+SPB][p] && hq[3+2*SPB][p]) first = p;
      if (be) begin
        m_st = 0; m_tmo = 0;
      end else if (bs) begin
        m_st = 1; m_cnt = 0; m_tmo = 0;
      end else if (m_st == 1) begin
        if (first >= 0) begin
          m_st = 2; m_sel = (first + NPH/2) % NPH;
        end else if (m_cnt == WIN - 1) begin
          m_st = 0; m_tmo = 1;
        end else m_cnt++;
      end
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      chk(lock_o == (m_st == 2), "R8 lock", lock_o, m_st == 2);
      chk(phase_o == m_sel, "R4 phase", phase_o, m_sel);
      chk(valid_o == m_vld, "R9 valid", valid_o, m_vld);
      chk(timeout_o == m_tmo, "R7 timeout", timeout_o, m_tmo);
      if (m_vld) chk(data_o == m_dat, "R2 data", data_o, m_dat);
    end
  end

  task automatic run_burst(input int d0, d1, d2, d3, input int pre, input bit mk,
                           input int tail, input bit do_end,
                           input bit e_lock, input int e_ph, input bit e_tmo,
                           input string tag);
    int bits[$];
    int wv[$];
    int d[4];
    d[0] = d0; d[1] = d1; d[2] = d2; d[3] = d3;
    for (int i = 0; i < pre; i++) bits.push_back(1);
    if (mk) begin bits.push_back(0); bits.push_back(1); end
    for (int i = 0; i < tail; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      bits.push_back(mk ? int'(lfsr[0]) : 0);
    end
    foreach (bits[i]) for (int k = 0; k < SPB; k++) wv.push_back(bits[i]);
    @(negedge clk_i);
    bs = 1'b1; samp = '0;
    for (int c = 0; c < wv.size() + 4; c++) begin
      @(negedge clk_i);
      if (c == 0) begin
        bs = 1'b0;
        chk(!lock_o && !timeout_o, "R10 start clears", {lock_o, timeout_o}, 0);
      end
      for (int p = 0; p < NPH; p++) begin
        int idx;
        idx = c - d[p];
        samp[p] = (idx >= 0 && idx < wv.size()) ? wv[idx][0] : 1'b0;
      end
    end
    chk(lock_o == e_lock, {tag, " lock"}, lock_o, e_lock);
    if (e_lock) chk(phase_o == e_ph, {tag, " phase"}, phase_o, e_ph);
    chk(timeout_o == e_tmo, {tag, " timeout"}, timeout_o, e_tmo);
    if (do_end) begin
      be = 1'b1; samp = '0;
      @(negedge clk_i);
      be = 1'b0;
      @(negedge clk_i);
      chk(!lock_o && !valid_o && !timeout_o, "R10 end clears", {lock_o, valid_o}, 0);
      repeat (10) @(negedge clk_i);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk(!lock_o && !valid_o && !timeout_o && phase_o == 0, "R1 reset", lock_o, 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    chk(!lock_o && !valid_o && !timeout_o && phase_o == 0, "R1 idle", lock_o, 0);
    // R3 R4: each phase in turn is earliest
    run_burst(0, 1, 1, 1, 16, 1, 20, 1, 1, 2, 0, "R4 first0");
    run_burst(1, 0, 1, 1, 16, 1, 20, 1, 1, 3, 0, "R4 first1");
    run_burst(1, 1, 0, 1, 16, 1, 20, 1, 1, 0, 0, "R3 first2");
    run_burst(1, 1, 1, 0, 16, 1, 20, 1, 1, 1, 0, "R4 first3");
    // R5 tie between phases 1 and 2
    run_burst(1, 0, 0, 1, 16, 1, 20, 1, 1, 3, 0, "R5 tie");
    // R7 no marker
    run_burst(0, 0, 0, 0, 16, 0, 12, 1, 0, 0, 1, "R7 no marker");
    // R6 marker beyond window
    run_burst(0, 1, 1, 1, 30, 1, 10, 1, 0, 0, 1, "R6 late marker");
    // R8 hold across later markers, then R10 restart without end
    run_burst(2, 2, 0, 2, 16, 1, 40, 0, 1, 0, 0, "R8 hold");
    run_burst(0, 1, 1, 1, 16, 1, 20, 0, 1, 2, 0, "R8 second");
    run_burst(1, 1, 1, 0, 16, 1, 20, 1, 1, 1, 0, "R10 restart");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule